// File: doc/BRIEF.md
# Multi-Bank Edge Interrupt Controller

This block watches up to 128 external lines, grouped in banks of 32, for rising and falling edges. A line with a matching trigger enable records a pending bit in its bank. The block drives one interrupt output, which is high whenever an enabled pending bit is present. Each bank also gives a one-cycle event pulse per line, gated by that bank's event mask. Software can raise a pending bit directly through a trigger register, and it acknowledges a pending bit by writing a 1 to that bit.

Line `k` belongs to bank `k / 32` at bit `k % 32`. The `NUM_BANKS` parameter selects the register layout. With one bank, each bank register sits at its own offset in a flat map. With two or more banks, the trigger registers and the mask/pending registers are placed in two interleaved regions. The `IMPL_MASK` parameter marks which lines exist. Register bits for lines that do not exist cannot be written and read as 0, so software can discover the implemented lines by writing all ones and reading back.

The block has no reset for its configuration or pending state, so software must initialise it: clear all pending bits, then program the masks and enables. `rst_n` only realigns the edge detector. The external lines are assumed to be synchronous to `clk`.

Top module: `mbank_edge_irq`

## Requirements
- R1: Register map. With NUM_BANKS=1 the offsets are: interrupt mask 0x00, event mask 0x04, rising enable 0x08, falling enable 0x0C, software trigger 0x10, pending 0x14. With more than one bank, bank b places rising enable at 0x20*b, falling enable at 0x20*b+0x04 and software trigger at 0x20*b+0x08; it places interrupt mask at 0x80+0x10*b, event mask at 0x80+0x10*b+0x04 and pending at 0x80+0x10*b+0x08. Mask and enable registers read back the last value written.
- R2: Edge detection. On an implemented line, a 0-to-1 change with its rising-enable bit at 1 sets the line's pending bit. A 1-to-0 change with its falling-enable bit at 1 also sets it. With both enable bits at 1, either edge sets it. The pending bit reads 1 on the clock edge that first samples the new line level.
- R3: A line whose rising-enable and falling-enable bits are both 0 never sets its pending bit.
- R4: Writing 1 to a pending bit clears it on that clock edge. Writing 0 leaves the bit unchanged.
- R5: If a detected edge and a clear write hit the same pending bit on the same clock edge, the bit ends up at 1.
- R6: Writing 1 to a software-trigger bit sets the matching pending bit on that clock edge. The software-trigger register always reads 0.
- R7: `irq_o` is 1 exactly when some implemented line has both its pending bit and its interrupt-mask bit at 1. A mask bit of 1 enables the line.
- R8: When a pending bit is set (by an edge or by a software trigger) and that line's event-mask bit is 1, the matching `evt_o` bit is 1 for the following cycle only. This does not depend on the interrupt mask.
- R9: For lines whose `IMPL_MASK` bit is 0, every register bit reads 0, writes have no effect, and the pending bit never reads 1.
- R10: `rst_n` low does not change the mask, enable or pending registers. No edge is detected while `rst_n` is low, and no edge is detected for a line level that is already present when `rst_n` is released.
- R11: A write to an address that decodes to no register, or to a bank at or above NUM_BANKS, changes nothing. A read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low realignment of the edge detector; configuration and pending state are not reset |
| lines_i | input | NUM_BANKS*32 | External lines, synchronous to clk |
| bus_we_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | NUM_BANKS*32 | Per-line one-cycle event pulses |

## Verification
The hardest case to reach is a line edge and a pending-clear write landing on the same clock edge. In that case the set must win. The bench first lowers the line, then raises it on the same falling clock edge on which it starts the clear write. This puts both actions on one rising edge. A second case that the ports cannot show directly is a line level that is already present when reset is released. The bench raises an enabled line while `rst_n` is low, then confirms that no pending bit appears until a fresh edge arrives after reset.

// File: rtl/mbei_pkg.sv
package mbei_pkg;

  localparam int unsigned LANES = 32;

  typedef enum logic [2:0] {
    K_NONE, K_IMASK, K_EMASK, K_RISE, K_FALL, K_SWT, K_PEND
  } regkind_e;

  typedef struct packed {
    logic     hit;
    logic [2:0] bank;
    regkind_e kind;
  } regsel_t;

  // Address decode; the layout variant is chosen by the bank count.
  function automatic regsel_t decode_addr(input logic [7:0] a,
                                          input int unsigned nbanks);
    regsel_t s;
    s.hit  = 1'b0;
    s.bank = 3'd0;
    s.kind = K_NONE;
    if (nbanks == 1) begin
      case (a)
        8'h00:   s.kind = K_IMASK;
        8'h04:   s.kind = K_EMASK;
        8'h08:   s.kind = K_RISE;
        8'h0C:   s.kind = K_FALL;
        8'h10:   s.kind = K_SWT;
        8'h14:   s.kind = K_PEND;
        default: s.kind = K_NONE;
      endcase
    end else if (!a[7]) begin
      s.bank = {1'b0, a[6:5]};
      case (a[4:0])
        5'h00:   s.kind = K_RISE;
        5'h04:   s.kind = K_FALL;
        5'h08:   s.kind = K_SWT;
        default: s.kind = K_NONE;
      endcase
    end else begin
      s.bank = a[6:4];
      case (a[3:0])
        4'h0:    s.kind = K_IMASK;
        4'h4:    s.kind = K_EMASK;
        4'h8:    s.kind = K_PEND;
        default: s.kind = K_NONE;
      endcase
    end
    s.hit = (s.kind != K_NONE) && (32'(s.bank) < nbanks);
    return s;
  endfunction

  function automatic logic [LANES-1:0] edge_bits(input logic [LANES-1:0] now,
                                                 input logic [LANES-1:0] prev,
                                                 input logic [LANES-1:0] rise,
                                                 input logic [LANES-1:0] fall);
    return (now & ~prev & rise) | (~now & prev & fall);
  endfunction

endpackage

// File: rtl/lineedge_det.sv
module lineedge_det
  import mbei_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lines_i,
  input  logic [LANES-1:0] rise_en_i,
  input  logic [LANES-1:0] fall_en_i,
  output logic [LANES-1:0] edge_o
);

  logic [LANES-1:0] prev_q;

  // History always follows the lines, so a level present at reset release
  // is not seen as an edge.
  always_ff @(posedge clk) prev_q <= lines_i;

  assign edge_o = rst_n ? edge_bits(lines_i, prev_q, rise_en_i, fall_en_i) : '0;

endmodule

// File: rtl/irqbank_regs.sv
module irqbank_regs
  import mbei_pkg::*;
#(
  parameter logic [LANES-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lines_i,
  input  logic             we_i,
  input  logic             sel_i,
  input  regkind_e         kind_i,
  input  logic [LANES-1:0] wdata_i,
  output logic [LANES-1:0] rdata_o,
  output logic [LANES-1:0] pend_o,
  output logic [LANES-1:0] imask_o,
  output logic [LANES-1:0] set_o,
  output logic [LANES-1:0] evt_o
);

  logic [LANES-1:0] imask_q, emask_q, rise_q, fall_q, pend_q, evt_q;
  logic [LANES-1:0] edge_v, swt_v, clr_v, set_v, wmask_v;
  logic             wr;

  assign wr      = we_i && sel_i;
  assign wmask_v = wdata_i & IMPL;
  assign swt_v   = (wr && kind_i == K_SWT)  ? wmask_v : '0;
  assign clr_v   = (wr && kind_i == K_PEND) ? wdata_i : '0;
  assign set_v   = (edge_v | swt_v) & IMPL;

  lineedge_det u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .lines_i   (lines_i),
    .rise_en_i (rise_q & IMPL),
    .fall_en_i (fall_q & IMPL),
    .edge_o    (edge_v)
  );

  // No reset: software initialises configuration and pending state.
  always_ff @(posedge clk) begin
    if (wr) begin
      case (kind_i)
        K_IMASK: imask_q <= wmask_v;
        K_EMASK: emask_q <= wmask_v;
        K_RISE:  rise_q  <= wmask_v;
        K_FALL:  fall_q  <= wmask_v;
        default: ;
      endcase
    end
    pend_q <= (pend_q & ~clr_v) | set_v;   // set wins over clear
    evt_q  <= set_v & emask_q & IMPL;
  end

  always_comb begin
    case (kind_i)
      K_IMASK: rdata_o = imask_q & IMPL;
      K_EMASK: rdata_o = emask_q & IMPL;
      K_RISE:  rdata_o = rise_q & IMPL;
      K_FALL:  rdata_o = fall_q & IMPL;
      K_PEND:  rdata_o = pend_q & IMPL;
      default: rdata_o = '0;
    endcase
  end

  assign pend_o  = pend_q & IMPL;
  assign imask_o = imask_q & IMPL;
  assign set_o   = set_v;
  assign evt_o   = evt_q;

  // R4: a clear without a simultaneous set leaves the bit at 0
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_v & ~set_v)) |=> ((pend_q & $past(clr_v & ~set_v)) == '0));

  // R5: every set bit is pending on the next cycle, even under a clear
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((pend_q & $past(set_v)) == $past(set_v)));

  // R6: a software trigger write makes the implemented bits pending
  p_swt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && kind_i == K_SWT) |=> ((pend_o & $past(wmask_v)) == $past(wmask_v)));

  // R8: an event pulse only follows a set in the previous cycle
  p_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_o) |-> ((evt_o & ~$past(set_v)) == '0));

endmodule

// File: rtl/mbank_edge_irq.sv
module mbank_edge_irq
  import mbei_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter logic [NUM_BANKS*LANES-1:0] IMPL_MASK = 96'h007F_FFFF_FFFF_FFFF_FFFF_FFFF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*LANES-1:0] lines_i,
  input  logic                       bus_we_i,
  input  logic [7:0]                 bus_addr_i,
  input  logic [LANES-1:0]           bus_wdata_i,
  output logic [LANES-1:0]           bus_rdata_o,
  output logic                       irq_o,
  output logic [NUM_BANKS*LANES-1:0] evt_o
);

  localparam int unsigned NL = NUM_BANKS * LANES;

  regsel_t           sel;
  logic [NL-1:0]     pend_all, imask_all, set_all, rd_all;

  assign sel = decode_addr(bus_addr_i, NUM_BANKS);

  initial begin
    if (NUM_BANKS < 1 || NUM_BANKS > 4)
      $error("NUM_BANKS must lie between 1 and 4");
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqbank_regs #(.IMPL(IMPL_MASK[b*LANES +: LANES])) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (lines_i[b*LANES +: LANES]),
      .we_i    (bus_we_i),
      .sel_i   (sel.hit && sel.bank == 3'(b)),
      .kind_i  (sel.kind),
      .wdata_i (bus_wdata_i),
      .rdata_o (rd_all[b*LANES +: LANES]),
      .pend_o  (pend_all[b*LANES +: LANES]),
      .imask_o (imask_all[b*LANES +: LANES]),
      .set_o   (set_all[b*LANES +: LANES]),
      .evt_o   (evt_o[b*LANES +: LANES])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++)
      if (sel.hit && sel.bank == 3'(b)) bus_rdata_o = rd_all[b*LANES +: LANES];
  end

  assign irq_o = |(pend_all & imask_all);

  // R7: the request can only rise after a bus write or a new pending set
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(bus_we_i || (|set_all)));

  // R11: unmapped addresses read as zero
  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel.hit |-> (bus_rdata_o == '0));

endmodule

// File: tb/mbank_edge_irq_tb_top.sv
module mbank_edge_irq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] lines = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [95:0] evt;

  logic [31:0] lines1 = '0;
  logic        we1 = 1'b0;
  logic [7:0]  addr1 = '0;
  logic [31:0] wdata1 = '0;
  logic [31:0] rdata1;
  logic        irq1;
  logic [31:0] evt1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;   // 250 MHz

  mbank_edge_irq dut_i (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .evt_o(evt)
  );

  mbank_edge_irq #(.NUM_BANKS(1), .IMPL_MASK(32'h0000_FFFF)) dut1_i (
    .clk(clk), .rst_n(rst_n), .lines_i(lines1), .bus_we_i(we1),
    .bus_addr_i(addr1), .bus_wdata_i(wdata1), .bus_rdata_o(rdata1),
    .irq_o(irq1), .evt_o(evt1)
  );

  // three-bank address helpers (R1)
  function automatic logic [7:0] a_rise(int b);  return 8'(32*b);        endfunction
  function automatic logic [7:0] a_fall(int b);  return 8'(32*b + 4);    endfunction
  function automatic logic [7:0] a_swt(int b);   return 8'(32*b + 8);    endfunction
  function automatic logic [7:0] a_imask(int b); return 8'(128 + 16*b);  endfunction
  function automatic logic [7:0] a_emask(int b); return 8'(132 + 16*b);  endfunction
  function automatic logic [7:0] a_pend(int b);  return 8'(136 + 16*b);  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wr1(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we1 = 1'b1; addr1 = a; wdata1 = d;
    @(negedge clk); we1 = 1'b0;
  endtask

  task automatic rd1(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr1 = a; #1 d = rdata1;
  endtask

  task automatic t_init;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int b = 0; b < 3; b++) begin
      wr(a_pend(b), 32'hFFFF_FFFF);
      wr(a_imask(b), 0); wr(a_emask(b), 0);
      wr(a_rise(b), 0);  wr(a_fall(b), 0);
    end
    wr1(8'h14, 32'hFFFF_FFFF);
    wr1(8'h00, 0); wr1(8'h04, 0); wr1(8'h08, 0); wr1(8'h0C, 0);
    rd(a_pend(1), v); chk("R4 init pending cleared", v, 0);
    @(negedge clk); chk("R7 init irq low", 32'(irq), 0);
  endtask

  task automatic t_map_r1;
    logic [31:0] v;
    wr(a_imask(1), 32'hA5A5_0F0F);
    rd(a_imask(1), v); chk("R1 imask bank1 0x90", v, 32'hA5A5_0F0F);
    rd(a_imask(0), v); chk("R1 imask bank0 0x80 untouched", v, 0);
    wr(a_rise(2), 32'h0000_1234);
    rd(a_rise(2), v); chk("R1 rise bank2 0x40", v, 32'h0000_1234);
    wr(a_fall(1), 32'h0000_00C3);
    rd(a_fall(1), v); chk("R1 fall bank1 0x24", v, 32'h0000_00C3);
    wr(a_imask(1), 0); wr(a_rise(2), 0); wr(a_fall(1), 0);
    wr1(8'h00, 32'h0000_1234);
    rd1(8'h00, v); chk("R1 single-bank imask 0x00", v, 32'h0000_1234);
    wr1(8'h00, 0);
  endtask

  task automatic t_edges_r2_r3;
    logic [31:0] v;
    wr(a_rise(0), 32'h5); wr(a_fall(0), 32'h6);
    @(negedge clk); lines[0] = 1'b1;
    rd(a_pend(0), v); chk("R2 rising edge line0", v, 32'h1);
    @(negedge clk); lines[1] = 1'b1;
    rd(a_pend(0), v); chk("R2 rising ignored when only falling enabled", v, 32'h1);
    @(negedge clk); lines[1] = 1'b0;
    rd(a_pend(0), v); chk("R2 falling edge line1", v, 32'h3);
    @(negedge clk); lines[2] = 1'b1;
    rd(a_pend(0), v); chk("R2 both-edge line2 rising", v, 32'h7);
    wr(a_pend(0), 32'h4);
    @(negedge clk); lines[2] = 1'b0;
    rd(a_pend(0), v); chk("R2 both-edge line2 falling", v, 32'h7);
    @(negedge clk); lines[3] = 1'b1;
    @(negedge clk); lines[3] = 1'b0;
    rd(a_pend(0), v); chk("R3 no enable no pending", v & 32'h8, 0);
  endtask

  task automatic t_clear_r4;
    logic [31:0] v;
    wr(a_pend(0), 32'h0);
    rd(a_pend(0), v); chk("R4 write zero keeps pending", v, 32'h7);
    wr(a_pend(0), 32'h2);
    rd(a_pend(0), v); chk("R4 write one clears bit1", v, 32'h5);
  endtask

  task automatic t_race_r5;
    logic [31:0] v;
    @(negedge clk); lines[0] = 1'b0;
    @(negedge clk); lines[0] = 1'b1; we = 1'b1; addr = a_pend(0); wdata = 32'h1;
    @(negedge clk); we = 1'b0;
    rd(a_pend(0), v); chk("R5 edge wins over clear", v & 32'h1, 32'h1);
    wr(a_pend(0), 32'hFFFF_FFFF);
    rd(a_pend(0), v); chk("R4 clear all bank0", v, 0);
    wr(a_rise(0), 0); wr(a_fall(0), 0);
  endtask

  task automatic t_swt_r6;
    logic [31:0] v;
    wr(a_swt(1), 32'h8000_0001);
    rd(a_pend(1), v); chk("R6 software trigger sets pending", v, 32'h8000_0001);
    rd(a_swt(1), v); chk("R6 software trigger reads zero", v, 0);
  endtask

  task automatic t_irq_r7;
    @(negedge clk); chk("R7 masked pending gives no irq", 32'(irq), 0);
    wr(a_imask(1), 32'h8000_0000);
    chk("R7 unmasked pending raises irq", 32'(irq), 1);
    wr(a_pend(1), 32'h8000_0000);
    chk("R7 clear unmasked bit drops irq", 32'(irq), 0);
    wr(a_pend(1), 32'hFFFF_FFFF); wr(a_imask(1), 0);
  endtask

  task automatic t_evt_r8;
    logic [31:0] v;
    wr(a_emask(0), 32'h10); wr(a_rise(0), 32'h10);
    @(negedge clk); lines[4] = 1'b1;
    @(negedge clk);
    chk("R8 event pulse high", 32'(evt[4]), 1);
    chk("R8 irq stays low with mask 0", 32'(irq), 0);
    @(negedge clk);
    chk("R8 event pulse one cycle", 32'(evt[4]), 0);
    rd(a_pend(0), v); chk("R8 pending also set", v, 32'h10);
    wr(a_pend(0), 32'hFFFF_FFFF); wr(a_emask(0), 0); wr(a_rise(0), 0);
  endtask

  task automatic t_unimpl_r9;
    logic [31:0] v;
    wr(a_rise(2), 32'hFFFF_FFFF);
    rd(a_rise(2), v); chk("R9 rise bank2 discovery", v, 32'h007F_FFFF);
    wr(a_imask(2), 32'hFFFF_FFFF);
    rd(a_imask(2), v); chk("R9 imask bank2 unimplemented bits zero", v, 32'h007F_FFFF);
    @(negedge clk); lines[95] = 1'b1;
    @(negedge clk);
    wr(a_swt(2), 32'h8000_0000);
    rd(a_pend(2), v); chk("R9 unimplemented line never pends", v, 0);
    chk("R9 irq stays low", 32'(irq), 0);
    wr(a_imask(2), 0); wr(a_rise(2), 0);
    wr1(8'h08, 32'hFFFF_FFFF);
    rd1(8'h08, v); chk("R9 single-bank rise discovery", v, 32'h0000_FFFF);
    wr1(8'h08, 0);
  endtask

  task automatic t_reset_r10;
    logic [31:0] v;
    wr(a_imask(0), 32'h20); wr(a_rise(0), 32'h20);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); lines[5] = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd(a_pend(0), v); chk("R10 no edge across reset", v, 0);
    rd(a_imask(0), v); chk("R10 imask survives reset", v, 32'h20);
    @(negedge clk); lines[5] = 1'b0;
    @(negedge clk); lines[5] = 1'b1;
    @(negedge clk); chk("R10 fresh edge after reset raises irq", 32'(irq), 1);
    wr(a_pend(0), 32'hFFFF_FFFF); wr(a_imask(0), 0); wr(a_rise(0), 0);
  endtask

  task automatic t_unmapped_r11;
    logic [31:0] v;
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'hB0, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h30, v); chk("R11 unmapped 0x30 reads zero", v, 0);
    rd(8'hB0, v); chk("R11 bank beyond count reads zero", v, 0);
    rd(a_rise(1), v); chk("R11 rise bank1 unchanged", v, 0);
    rd(a_fall(0), v); chk("R11 fall bank0 unchanged", v, 0);
    rd(a_imask(1), v); chk("R11 imask bank1 unchanged", v, 0);
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_init();
    t_map_r1();
    t_edges_r2_r3();
    t_clear_r4();
    t_race_r5();
    t_swt_r6();
    t_irq_r7();
    t_evt_r8();
    t_unimpl_r9();
    t_reset_r10();
    t_unmapped_r11();
    finish_run();
  end

endmodule